// File: doc/BRIEF.md
# Host-Side Indexed Configuration and Interrupt Register Block

This block sits between a host register bus and an embedded signal processor. It presents a small set of host-addressable ports. One is a slave control register carrying a soft-reset bit, a configuration-window enable and a clock-control field. Two more form an index/data pair into a bank of byte-wide configuration registers. The last two are an interrupt enable and a pending-interrupt source register. The signal-processor side raises interrupt sources with single-cycle event pulses. The block drives one interrupt line towards the host.

The host opens the configuration window by setting the window-enable bit. It writes a byte index to the index port, then reads or writes the data port. When the window is closed, the index and data ports are inert. To acknowledge interrupts, the host reads the source register and writes back the bitwise complement of that value. Every bit written as zero is dropped and every bit written as one is kept. While the soft-reset bit is set, every register other than slave control is held at its reset value.

Top module: `hostreg_top`

## Requirements
- R1: After `rst_n` is released, every port reads zero, `host_irq` is low, `soft_rst` is low and `cfg_bytes` is all zero.
- R2: The slave control port (address 0) stores bit 0 as soft reset, bit 1 as window enable and bits [3:2] as clock control. Its upper bits read as zero. `soft_rst` and `clk_ctl` show the stored fields.
- R3: With the window enable set, a write to address 1 stores a byte index. A write to address 2 stores `host_wdata[7:0]` in the byte selected by that index. Address 2 reads the selected byte and address 1 reads the index.
- R4: With the window enable clear, addresses 1 and 2 read zero and writes to them change neither the index nor any byte.
- R5: Configuration byte i appears on `cfg_bytes[8*i+7:8*i]`.
- R6: From the clock edge after the soft-reset bit reads one, the index, all bytes, the interrupt enable and the sources are zero. Writes and event pulses do not change them while the bit stays set. The slave control register keeps its value and can be cleared by the host to release soft reset.
- R7: Address 3 bit 0 is the interrupt enable, readable back, with other bits reading zero.
- R8: A one on any bit of `dsp_evt` for a cycle sets the matching bit of the source register (address 4).
- R9: A write to address 4 keeps each source bit written as one and clears each bit written as zero.
- R10: An event pulse arriving in the same cycle as a write to address 4 sets its bit regardless of the written value.
- R11: `host_irq` is high exactly when the interrupt enable is set and at least one source bit is pending.
- R12: Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 3 | Host port select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the selected port, combinational |
| dsp_evt | input | 16 | Interrupt source set pulses from the processor side |
| host_irq | output | 1 | Interrupt line to the host |
| soft_rst | output | 1 | Soft reset towards the processor |
| clk_ctl | output | 2 | Clock-control field |
| cfg_bytes | output | 128 | All configuration bytes, byte i at bits [8*i+7:8*i] |

## Verification
The embedded properties watch several things on every cycle. An event pulse must leave its source bit set even when a clear write coincides with it. A clear write without events must leave exactly the AND of the old sources and the written word. Soft reset must empty the byte bank, the index and the interrupt state one edge later. Writes through a closed window must leave the bank and index untouched, and an open-window data write must land at the index held before the edge. Only the bench scenarios can show the rest: the port map and readback of each field, zero readback through a closed window, the byte placement on the flat output, the interrupt line against its enable, and the release of soft reset by a host write.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

    localparam int unsigned PORT_W = 3;

    typedef enum logic [PORT_W-1:0] {
        PORT_SLV  = 3'd0,
        PORT_CIDX = 3'd1,
        PORT_CDAT = 3'd2,
        PORT_BCTL = 3'd3,
        PORT_ISRC = 3'd4
    } port_e;

    // slave control field positions
    localparam int unsigned SLV_SRST_BIT = 0;
    localparam int unsigned SLV_WIN_BIT  = 1;
    localparam int unsigned SLV_CLK_LSB  = 2;

    // bridge control field position
    localparam int unsigned BCTL_IEN_BIT = 0;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/hostreg_slvctl.sv
module hostreg_slvctl
    import hostreg_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CLK_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              srst_o,
    output logic              win_o,
    output logic [CLK_W-1:0]  clk_ctl_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned FIELD_W = SLV_CLK_LSB + CLK_W;

    typedef struct packed {
        logic [CLK_W-1:0] clk_ctl;
        logic             win;
        logic             srst;
    } slv_t;

    slv_t slv_d, slv_q;

    always_comb begin
        slv_d = slv_q;
        if (wr_i) begin
            slv_d.srst    = wdata_i[SLV_SRST_BIT];
            slv_d.win     = wdata_i[SLV_WIN_BIT];
            slv_d.clk_ctl = wdata_i[SLV_CLK_LSB +: CLK_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slv_q <= '0;
        else        slv_q <= slv_d;
    end

    logic spare_unused;
    assign spare_unused = ^wdata_i[DATA_W-1:FIELD_W];

    always_comb begin
        rdata_o = '0;
        rdata_o[SLV_SRST_BIT]            = slv_q.srst;
        rdata_o[SLV_WIN_BIT]             = slv_q.win;
        rdata_o[SLV_CLK_LSB +: CLK_W]    = slv_q.clk_ctl;
    end

    assign srst_o    = slv_q.srst;
    assign win_o     = slv_q.win;
    assign clk_ctl_o = slv_q.clk_ctl;

    // a host write lands on the next edge
    p_slv_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (srst_o == $past(wdata_i[SLV_SRST_BIT])) && (win_o == $past(wdata_i[SLV_WIN_BIT])));

endmodule

// File: rtl/hostreg_cfgspace.sv
module hostreg_cfgspace
    import hostreg_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NCFG   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   win_i,
    input  logic                   srst_i,
    input  logic                   idx_wr_i,
    input  logic                   dat_wr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [DATA_W-1:0]      idx_rdata_o,
    output logic [DATA_W-1:0]      dat_rdata_o,
    output logic [NCFG*BYTE_W-1:0] bytes_o
);

    localparam int unsigned IDX_W = (NCFG > 1) ? $clog2(NCFG) : 1;

    typedef struct packed {
        logic [IDX_W-1:0]             idx;
        logic [NCFG-1:0][BYTE_W-1:0]  bank;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (srst_i) begin
            cfg_d = '0;
        end else if (win_i) begin
            if (idx_wr_i) cfg_d.idx = wdata_i[IDX_W-1:0];
            if (dat_wr_i) cfg_d.bank[cfg_q.idx] = wdata_i[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    logic upper_unused;
    assign upper_unused = ^wdata_i[DATA_W-1:BYTE_W];

    always_comb begin
        idx_rdata_o = '0;
        dat_rdata_o = '0;
        if (win_i) begin
            idx_rdata_o[IDX_W-1:0]  = cfg_q.idx;
            dat_rdata_o[BYTE_W-1:0] = cfg_q.bank[cfg_q.idx];
        end
    end

    for (genvar g = 0; g < NCFG; g++) begin : g_flat
        assign bytes_o[g*BYTE_W +: BYTE_W] = cfg_q.bank[g];
    end

    // closed window leaves the bank and the index alone
    p_closed_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((idx_wr_i || dat_wr_i) && !win_i && !srst_i) |=> $stable(cfg_q));

    // an open-window data write lands at the index held before the edge
    p_byte_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_i && win_i && !srst_i) |=> (cfg_q.bank[$past(cfg_q.idx)] == $past(wdata_i[BYTE_W-1:0])));

    // soft reset empties the space one edge later
    p_srst_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (cfg_q == '0));

endmodule

// File: rtl/hostreg_irq.sv
module hostreg_irq
    import hostreg_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_i,
    input  logic              bctl_wr_i,
    input  logic              src_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SRC_W-1:0]  evt_i,
    output logic [DATA_W-1:0] bctl_rdata_o,
    output logic [DATA_W-1:0] src_rdata_o,
    output logic              irq_o
);

    typedef struct packed {
        logic             ien;
        logic [SRC_W-1:0] src;
    } irq_t;

    irq_t irq_d, irq_q;
    logic [SRC_W-1:0] keep_mask;

    always_comb begin
        keep_mask = src_wr_i ? wdata_i[SRC_W-1:0] : '1;
        irq_d     = irq_q;
        if (srst_i) begin
            irq_d = '0;
        end else begin
            if (bctl_wr_i) irq_d.ien = wdata_i[BCTL_IEN_BIT];
            // complement-clear first, then the set pulses win
            irq_d.src = (irq_q.src & keep_mask) | evt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    always_comb begin
        bctl_rdata_o               = '0;
        bctl_rdata_o[BCTL_IEN_BIT] = irq_q.ien;
        src_rdata_o                = '0;
        src_rdata_o[SRC_W-1:0]     = irq_q.src;
    end

    assign irq_o = irq_q.ien && (irq_q.src != '0);

    // every pulsed source is pending after the edge, clear or not
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i != '0) && !srst_i) |=> ((irq_q.src & $past(evt_i)) == $past(evt_i)));

    // a quiet clear write keeps exactly the bits written as one
    p_cpl_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr_i && (evt_i == '0) && !srst_i) |=> (irq_q.src == ($past(irq_q.src) & $past(wdata_i[SRC_W-1:0]))));

    // soft reset drops interrupt state and the line
    p_srst_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> ((irq_q == '0) && !irq_o));

endmodule

// File: rtl/hostreg_top.sv
module hostreg_top
    import hostreg_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CLK_W  = 2,
    parameter int unsigned NCFG   = 16,
    parameter int unsigned SRC_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic [PORT_W-1:0]      host_addr,
    input  logic [DATA_W-1:0]      host_wdata,
    output logic [DATA_W-1:0]      host_rdata,
    input  logic [SRC_W-1:0]       dsp_evt,
    output logic                   host_irq,
    output logic                   soft_rst,
    output logic [CLK_W-1:0]       clk_ctl,
    output logic [NCFG*BYTE_W-1:0] cfg_bytes
);

    logic wr_slv, wr_cidx, wr_cdat, wr_bctl, wr_isrc;
    logic win;
    logic [DATA_W-1:0] rd_slv, rd_cidx, rd_cdat, rd_bctl, rd_isrc;

    always_comb begin
        wr_slv  = host_wr && (host_addr == PORT_SLV);
        wr_cidx = host_wr && (host_addr == PORT_CIDX);
        wr_cdat = host_wr && (host_addr == PORT_CDAT);
        wr_bctl = host_wr && (host_addr == PORT_BCTL);
        wr_isrc = host_wr && (host_addr == PORT_ISRC);
    end

    hostreg_slvctl #(.DATA_W(DATA_W), .CLK_W(CLK_W)) u_slv (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_slv),
        .wdata_i   (host_wdata),
        .srst_o    (soft_rst),
        .win_o     (win),
        .clk_ctl_o (clk_ctl),
        .rdata_o   (rd_slv)
    );

    hostreg_cfgspace #(.DATA_W(DATA_W), .NCFG(NCFG)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_i       (win),
        .srst_i      (soft_rst),
        .idx_wr_i    (wr_cidx),
        .dat_wr_i    (wr_cdat),
        .wdata_i     (host_wdata),
        .idx_rdata_o (rd_cidx),
        .dat_rdata_o (rd_cdat),
        .bytes_o     (cfg_bytes)
    );

    hostreg_irq #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .srst_i       (soft_rst),
        .bctl_wr_i    (wr_bctl),
        .src_wr_i     (wr_isrc),
        .wdata_i      (host_wdata),
        .evt_i        (dsp_evt),
        .bctl_rdata_o (rd_bctl),
        .src_rdata_o  (rd_isrc),
        .irq_o        (host_irq)
    );

    always_comb begin
        case (host_addr)
            PORT_SLV:  host_rdata = rd_slv;
            PORT_CIDX: host_rdata = rd_cidx;
            PORT_CDAT: host_rdata = rd_cdat;
            PORT_BCTL: host_rdata = rd_bctl;
            PORT_ISRC: host_rdata = rd_isrc;
            default:   host_rdata = '0;
        endcase
    end

    // the line only rises after a pulse or an enable write
    p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> ($past(dsp_evt) != '0) || $past(wr_bctl));

endmodule

// File: tb/hostreg_top_test.sv
module hostreg_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 25;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_wr = 1'b0;
    logic [2:0]   host_addr = '0;
    logic [15:0]  host_wdata = '0;
    logic [15:0]  host_rdata;
    logic [15:0]  dsp_evt = '0;
    logic         host_irq;
    logic         soft_rst;
    logic [1:0]   clk_ctl;
    logic [127:0] cfg_bytes;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostreg_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .dsp_evt    (dsp_evt),
        .host_irq   (host_irq),
        .soft_rst   (soft_rst),
        .clk_ctl    (clk_ctl),
        .cfg_bytes  (cfg_bytes)
    );

    // {wr, addr, wdata, expected read, requirement number}
    localparam logic [39:0] VECS [0:NVEC-1] = '{
        {1'b0, 3'd0, 16'h0000, 16'h0000, 4'd1},   // R1 slave control clear
        {1'b0, 3'd4, 16'h0000, 16'h0000, 4'd1},   // R1 no sources
        {1'b0, 3'd3, 16'h0000, 16'h0000, 4'd1},   // R1 enable clear
        {1'b1, 3'd2, 16'h005A, 16'h0000, 4'd4},   // R4 write through closed window
        {1'b1, 3'd0, 16'h0002, 16'h0000, 4'd2},   // open window
        {1'b0, 3'd2, 16'h0000, 16'h0000, 4'd4},   // R4 byte 0 untouched
        {1'b1, 3'd1, 16'h0003, 16'h0000, 4'd3},
        {1'b1, 3'd2, 16'h00A5, 16'h0000, 4'd3},
        {1'b1, 3'd1, 16'h000F, 16'h0000, 4'd3},
        {1'b1, 3'd2, 16'h00C3, 16'h0000, 4'd3},
        {1'b0, 3'd2, 16'h0000, 16'h00C3, 4'd3},   // R3 byte 15
        {1'b1, 3'd1, 16'h0003, 16'h0000, 4'd3},
        {1'b0, 3'd2, 16'h0000, 16'h00A5, 4'd3},   // R3 byte 3
        {1'b0, 3'd1, 16'h0000, 16'h0003, 4'd3},   // R3 index readback
        {1'b1, 3'd0, 16'h000E, 16'h0000, 4'd2},
        {1'b0, 3'd0, 16'h0000, 16'h000E, 4'd2},   // R2 fields
        {1'b1, 3'd0, 16'hFFFE, 16'h0000, 4'd2},
        {1'b0, 3'd0, 16'h0000, 16'h000E, 4'd2},   // R2 upper bits read zero
        {1'b1, 3'd0, 16'h0000, 16'h0000, 4'd4},   // close window
        {1'b0, 3'd2, 16'h0000, 16'h0000, 4'd4},   // R4 data port reads zero
        {1'b0, 3'd1, 16'h0000, 16'h0000, 4'd4},   // R4 index port reads zero
        {1'b1, 3'd1, 16'h0007, 16'h0000, 4'd4},   // ignored index write
        {1'b1, 3'd0, 16'h0002, 16'h0000, 4'd4},   // reopen
        {1'b0, 3'd1, 16'h0000, 16'h0003, 4'd4},   // R4 index kept
        {1'b0, 3'd5, 16'h0000, 16'h0000, 4'd12}   // R12 unused port
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic host_read(input string req, input logic [2:0] a, input logic [15:0] exp);
        host_addr = a;
        #1;
        check(req, $sformatf("read port %0d", a), {16'h0, host_rdata}, {16'h0, exp});
    endtask

    task automatic pulse(input logic [15:0] e);
        @(negedge clk);
        dsp_evt = e;
        @(negedge clk);
        dsp_evt = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 outputs after reset
        check("R1", "irq", {31'h0, host_irq}, 32'h0);
        check("R1", "soft_rst", {31'h0, soft_rst}, 32'h0);
        check("R1", "cfg_bytes", {31'h0, (cfg_bytes != '0)}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i][39]) host_write(VECS[i][38:36], VECS[i][35:20]);
            else host_read($sformatf("R%0d", VECS[i][3:0]), VECS[i][38:36], VECS[i][19:4]);
        end
        host_read("R12", 3'd7, 16'h0000);

        // R5 flat byte placement
        check("R5", "byte3", {24'h0, cfg_bytes[3*8 +: 8]}, 32'hA5);
        check("R5", "byte15", {24'h0, cfg_bytes[15*8 +: 8]}, 32'hC3);
        check("R5", "byte7", {24'h0, cfg_bytes[7*8 +: 8]}, 32'h00);

        // R2 clock field output
        host_write(3'd0, 16'h000A);
        check("R2", "clk_ctl", {30'h0, clk_ctl}, 32'h2);

        // R7 enable readback
        host_write(3'd3, 16'hFFFF);
        host_read("R7", 3'd3, 16'h0001);
        check("R11", "irq no pending", {31'h0, host_irq}, 32'h0);

        // R8 pulses set sources
        pulse(16'h0011);
        host_read("R8", 3'd4, 16'h0011);
        check("R11", "irq pending", {31'h0, host_irq}, 32'h1);

        // R9 complement clear of bit 0
        host_write(3'd4, 16'hFFFE);
        host_read("R9", 3'd4, 16'h0010);

        // R10 set in same cycle as clear-all
        @(negedge clk);
        host_wr = 1'b1; host_addr = 3'd4; host_wdata = 16'h0000; dsp_evt = 16'h0100;
        @(negedge clk);
        host_wr = 1'b0; dsp_evt = '0;
        host_read("R10", 3'd4, 16'h0100);

        // R11 enable gates the line
        host_write(3'd3, 16'h0000);
        check("R11", "irq disabled", {31'h0, host_irq}, 32'h0);
        host_write(3'd3, 16'h0001);
        check("R11", "irq reenabled", {31'h0, host_irq}, 32'h1);

        // R6 soft reset with window open, clock field 1
        host_write(3'd0, 16'h0007);
        @(negedge clk);
        check("R6", "soft_rst", {31'h0, soft_rst}, 32'h1);
        check("R6", "clk_ctl kept", {30'h0, clk_ctl}, 32'h1);
        check("R6", "cfg_bytes cleared", {31'h0, (cfg_bytes != '0)}, 32'h0);
        check("R6", "irq dropped", {31'h0, host_irq}, 32'h0);
        host_read("R6", 3'd4, 16'h0000);
        host_read("R6", 3'd3, 16'h0000);
        host_read("R6", 3'd1, 16'h0000);
        pulse(16'h0040);
        host_read("R6", 3'd4, 16'h0000);
        host_write(3'd3, 16'h0001);
        host_read("R6", 3'd3, 16'h0000);
        host_write(3'd2, 16'h0077);
        check("R6", "byte write held", {31'h0, (cfg_bytes != '0)}, 32'h0);
        host_read("R6", 3'd0, 16'h0007);

        // R6 release by host write
        host_write(3'd0, 16'h0002);
        check("R6", "released", {31'h0, soft_rst}, 32'h0);
        pulse(16'h0002);
        host_read("R6", 3'd4, 16'h0002);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule